// File: doc/BRIEF.md
# Block-Linear Surface Address Swizzler

This block turns a byte coordinate on a tiled surface into a byte address. The coordinate is a horizontal position in bytes and a vertical position in lines. The surface is cut into tiles of 64 bytes by 8 lines, here called GOBs. Inside each GOB the bytes are not in raster order. The GOB is split into a 4 by 4 grid of 16-byte by 2-line sectors, and the sectors are visited in an interleaved Z order.

GOBs are stacked vertically into blocks of 2^v GOBs. The stack height v is chosen at run time through a 4-bit code, and only codes 0 to 5 are legal. Blocks run left to right along a block row, and block rows run from top to bottom. The stride of a block row is set by a pitch input counted in blocks. A base address is added to every result.

Coordinates arrive on a valid/ready stream, one per cycle. Addresses leave on a valid/ready stream in the order the coordinates were accepted. The pitch, height code and base are captured together with each coordinate, so they may change on any beat.

Top module: `gob_addr_swizzler`

## Requirements
- R1: The offset inside a GOB is sector*32 + y[0]*16 + x[3:0]. The sector index is {y[2], x[5], y[1], x[4]}, with bit 3 on the left, so a horizontal sector bit is always the least significant bit of each interleaved pair.
- R2: GOB row g = y>>3 lies at position g mod 2^v inside its block, and each step of that position adds 512 bytes.
- R3: The block column is x>>6, and each block occupies 512*2^v bytes.
- R4: The block row is (y>>3)>>v, and each block row spans pitch_blocks blocks.
- R5: The output address is base_addr + (row*pitch_blocks + col)*512*2^v + gob_pos*512 + offset, truncated to ADDR_W bits.
- R6: cfg_err is high in any cycle where blk_h_code is above 5. A coordinate accepted with such a code produces no output beat.
- R7: With out_ready held high, the address for a coordinate accepted at clock edge k is handed off at edge k+2. A new coordinate can be accepted on every edge.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_addr holds its value.
- R9: Output addresses leave in the order their coordinates were accepted. in_ready is high whenever the first pipeline stage is empty.
- R10: During reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coordinate beat present |
| in_ready | output | 1 | Coordinate accepted at this edge when high |
| in_x | input | X_W | Horizontal byte position |
| in_y | input | Y_W | Vertical line position |
| pitch_blocks | input | PITCH_W | Blocks per block row |
| blk_h_code | input | 4 | log2 of GOBs per block, legal values 0 to 5 |
| base_addr | input | ADDR_W | Surface base byte address |
| out_valid | output | 1 | Address beat present |
| out_ready | input | 1 | Downstream takes the address at this edge |
| out_addr | output | ADDR_W | Swizzled byte address |
| cfg_err | output | 1 | Current block-height code is illegal |

## Verification
Each address is due two edges after its coordinate is accepted, provided the downstream side does not stall. The bench records the cycle of every acceptance next to the expected address in its queue. While out_ready is held high, it checks that the hand-off happens exactly two edges later. During random stalls it checks only order and value, and it checks that a stalled output holds steady. cfg_err is combinational, so it is checked in the same cycle the code is driven. Coordinates carrying an illegal code are never queued, so any output produced for them shows up as a mismatch or as an output with nothing queued.

// File: rtl/gobsw_pkg.sv
package gobsw_pkg;
  // Fixed geometry of one GOB and its sectors.
  localparam int GOB_W_LOG2    = 6;   // 64 bytes wide
  localparam int GOB_H_LOG2    = 3;   // 8 lines tall
  localparam int SECT_W_LOG2   = 4;   // sector 16 bytes wide
  localparam int SECT_H_LOG2   = 1;   // sector 2 lines tall
  localparam int SECT_AXIS     = GOB_W_LOG2 - SECT_W_LOG2;  // 2 bits per axis
  localparam int GOB_B_LOG2    = GOB_W_LOG2 + GOB_H_LOG2;   // 512 bytes
  localparam int HCODE_W       = 4;
  localparam int V_W           = 3;
  localparam int MAX_V         = 5;
  localparam int STACK_W       = MAX_V;                     // GOB position in block

  typedef logic [V_W-1:0]        vlog_t;
  typedef logic [GOB_B_LOG2-1:0] gob_off_t;
  typedef logic [STACK_W-1:0]    stack_pos_t;
endpackage

// File: rtl/gobsw_gob_offset.sv
module gobsw_gob_offset
  import gobsw_pkg::*;
(
  input  logic [GOB_W_LOG2-1:0] x_lo,
  input  logic [GOB_H_LOG2-1:0] y_lo,
  output gob_off_t              off
);
  localparam int SIDX_W = 2 * SECT_AXIS;

  logic [SIDX_W-1:0] sect_idx;

  // Morton interleave of sector column and sector row, column bit lowest.
  for (genvar i = 0; i < SECT_AXIS; i++) begin : g_morton
    assign sect_idx[2*i]   = x_lo[SECT_W_LOG2 + i];
    assign sect_idx[2*i+1] = y_lo[SECT_H_LOG2 + i];
  end

  // Raster order inside a sector: line bit above the byte bits.
  assign off = {sect_idx, y_lo[SECT_H_LOG2-1:0], x_lo[SECT_W_LOG2-1:0]};
endmodule

// File: rtl/gobsw_split.sv
module gobsw_split
  import gobsw_pkg::*;
#(
  parameter int X_W = 16,
  parameter int Y_W = 16,
  localparam int COL_W = X_W - GOB_W_LOG2,
  localparam int ROW_W = Y_W - GOB_H_LOG2
) (
  input  logic [X_W-1:0]   x,
  input  logic [Y_W-1:0]   y,
  input  vlog_t            v,
  output gob_off_t         off,
  output logic [COL_W-1:0] blk_col,
  output stack_pos_t       stack_pos,
  output logic [ROW_W-1:0] blk_row
);
  logic [ROW_W-1:0]   gob_row;
  logic [STACK_W:0]   stack_mask;

  gobsw_gob_offset u_off (
    .x_lo (x[GOB_W_LOG2-1:0]),
    .y_lo (y[GOB_H_LOG2-1:0]),
    .off  (off)
  );

  always_comb begin
    gob_row    = y[Y_W-1:GOB_H_LOG2];
    blk_col    = x[X_W-1:GOB_W_LOG2];
    stack_mask = ((STACK_W+1)'(1) << v) - (STACK_W+1)'(1);
    stack_pos  = gob_row[STACK_W-1:0] & stack_mask[STACK_W-1:0];
    blk_row    = gob_row >> v;
  end
endmodule

// File: rtl/gobsw_addr_calc.sv
module gobsw_addr_calc
  import gobsw_pkg::*;
#(
  parameter int PITCH_W = 12,
  parameter int COL_W   = 10,
  parameter int ROW_W   = 13,
  parameter int ADDR_W  = 40,
  localparam int LIN_W  = ROW_W + PITCH_W + 1
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [ROW_W-1:0]   blk_row,
  input  logic [COL_W-1:0]   blk_col,
  input  stack_pos_t         stack_pos,
  input  gob_off_t           off,
  input  vlog_t              v,
  output logic [ADDR_W-1:0]  addr
);
  logic [LIN_W-1:0]  blk_lin;
  logic [ADDR_W-1:0] blk_term;
  logic [ADDR_W-1:0] stack_term;

  always_comb begin
    blk_lin    = LIN_W'(blk_row) * LIN_W'(pitch) + LIN_W'(blk_col);
    blk_term   = ADDR_W'(blk_lin) << (GOB_B_LOG2 + int'(v));
    stack_term = ADDR_W'(stack_pos) << GOB_B_LOG2;
    addr       = base + blk_term + stack_term + ADDR_W'(off);
  end
endmodule

// File: rtl/gob_addr_swizzler.sv
module gob_addr_swizzler
  import gobsw_pkg::*;
#(
  parameter int X_W     = 16,
  parameter int Y_W     = 16,
  parameter int PITCH_W = 12,
  parameter int ADDR_W  = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [X_W-1:0]     in_x,
  input  logic [Y_W-1:0]     in_y,
  input  logic [PITCH_W-1:0] pitch_blocks,
  input  logic [HCODE_W-1:0] blk_h_code,
  input  logic [ADDR_W-1:0]  base_addr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic               cfg_err
);
  localparam int COL_W = X_W - GOB_W_LOG2;
  localparam int ROW_W = Y_W - GOB_H_LOG2;

  // Input decode
  vlog_t            in_v;
  gob_off_t         sp_off;
  logic [COL_W-1:0] sp_col;
  stack_pos_t       sp_stack;
  logic [ROW_W-1:0] sp_row;

  // Stage 1 state
  logic               s1_valid_q, s1_valid_d;
  gob_off_t           s1_off_q;
  logic [COL_W-1:0]   s1_col_q;
  stack_pos_t         s1_stack_q;
  logic [ROW_W-1:0]   s1_row_q;
  vlog_t              s1_v_q;
  logic [PITCH_W-1:0] s1_pitch_q;
  logic [ADDR_W-1:0]  s1_base_q;
  logic               s1_load;

  // Stage 2 state
  logic              s2_valid_q, s2_valid_d;
  logic [ADDR_W-1:0] s2_addr_q;
  logic [ADDR_W-1:0] calc_addr;
  logic              s2_load;

  logic s1_en, s2_en;

  assign in_v    = blk_h_code[V_W-1:0];
  assign cfg_err = (blk_h_code > HCODE_W'(MAX_V));

  gobsw_split #(.X_W(X_W), .Y_W(Y_W)) u_split (
    .x         (in_x),
    .y         (in_y),
    .v         (in_v),
    .off       (sp_off),
    .blk_col   (sp_col),
    .stack_pos (sp_stack),
    .blk_row   (sp_row)
  );

  gobsw_addr_calc #(
    .PITCH_W (PITCH_W),
    .COL_W   (COL_W),
    .ROW_W   (ROW_W),
    .ADDR_W  (ADDR_W)
  ) u_calc (
    .base      (s1_base_q),
    .pitch     (s1_pitch_q),
    .blk_row   (s1_row_q),
    .blk_col   (s1_col_q),
    .stack_pos (s1_stack_q),
    .off       (s1_off_q),
    .v         (s1_v_q),
    .addr      (calc_addr)
  );

  // Next-state and enables
  always_comb begin
    s2_en      = !s2_valid_q || out_ready;
    s1_en      = !s1_valid_q || s2_en;
    s1_load    = s1_en && in_valid && !cfg_err;
    s1_valid_d = s1_en ? (in_valid && !cfg_err) : s1_valid_q;
    s2_load    = s2_en && s1_valid_q;
    s2_valid_d = s2_en ? s1_valid_q : s2_valid_q;
  end

  assign in_ready  = s1_en;
  assign out_valid = s2_valid_q;
  assign out_addr  = s2_addr_q;

  // Valid flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
    end
  end

  // Stage 1 payload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_off_q   <= '0;
      s1_col_q   <= '0;
      s1_stack_q <= '0;
      s1_row_q   <= '0;
      s1_v_q     <= '0;
      s1_pitch_q <= '0;
      s1_base_q  <= '0;
    end else if (s1_load) begin
      s1_off_q   <= sp_off;
      s1_col_q   <= sp_col;
      s1_stack_q <= sp_stack;
      s1_row_q   <= sp_row;
      s1_v_q     <= in_v;
      s1_pitch_q <= pitch_blocks;
      s1_base_q  <= base_addr;
    end
  end

  // Stage 2 payload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_addr_q <= '0;
    end else if (s2_load) begin
      s2_addr_q <= calc_addr;
    end
  end

  // R8: a stalled address stays put
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));

  // R6: an illegal stack height never enters the pipeline
  a_r6_legal_height: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid_q |-> (s1_v_q <= V_W'(MAX_V)));

  // R9: an empty first stage always takes input
  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid_q |-> in_ready);

  // R7: a new output beat always comes from a filled first stage
  a_r7_beat_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(out_valid) |-> $past(s1_valid_q));
endmodule

// File: tb/gob_addr_swizzler_tb_top.sv
`timescale 1ns/100ps
module gob_addr_swizzler_tb_top;
  localparam int X_W = 16, Y_W = 16, PITCH_W = 12, ADDR_W = 40;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic               in_ready;
  logic [X_W-1:0]     in_x;
  logic [Y_W-1:0]     in_y;
  logic [PITCH_W-1:0] pitch_blocks;
  logic [3:0]         blk_h_code;
  logic [ADDR_W-1:0]  base_addr;
  logic               out_valid;
  logic               out_ready;
  logic [ADDR_W-1:0]  out_addr;
  logic               cfg_err;

  gob_addr_swizzler #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_x, .in_y, .pitch_blocks,
    .blk_h_code, .base_addr, .out_valid, .out_ready, .out_addr, .cfg_err
  );

  always #2 clk = ~clk;

  int     n_checks = 0;
  int     n_fail   = 0;
  int     cyc      = 0;
  bit     stall_mode = 1'b0;
  bit     done = 1'b0;
  longint exp_q[$];
  int     acc_q[$];
  bit     nost_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Address model written from R1..R5
  function automatic longint model(longint x, longint y, longint p, int v, longint base);
    longint off, gr, gpos, br, bc, a;
    off  = (((y >> 2) & 1) << 8) | (((x >> 5) & 1) << 7) | (((y >> 1) & 1) << 6)
         | (((x >> 4) & 1) << 5) | ((y & 1) << 4) | (x & 15);
    gr   = y >> 3;
    gpos = gr & ((64'd1 << v) - 1);
    br   = gr >> v;
    bc   = x >> 6;
    a    = base + ((br * p + bc) << (9 + v)) + (gpos << 9) + off;
    return a & ((64'd1 << ADDR_W) - 1);
  endfunction

  // Driver: present one coordinate until accepted, queue its expectation
  task automatic drive(longint x, longint y, longint p, int code, longint base);
    bit acc;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      in_valid     = 1'b1;
      in_x         = X_W'(x);
      in_y         = Y_W'(y);
      pitch_blocks = PITCH_W'(p);
      blk_h_code   = 4'(code);
      base_addr    = ADDR_W'(base);
      #0.5;
      check(cfg_err == (code > 5), "R6 cfg_err", longint'(cfg_err), longint'(code > 5));
      acc = in_ready;
      if (acc && code <= 5) begin
        exp_q.push_back(model(x, y, p, code, base));
        acc_q.push_back(cyc + 1);
        nost_q.push_back(!stall_mode);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Downstream ready pattern
  always @(negedge clk) out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;

  // Monitor / scoreboard
  initial begin
    bit     held_v;
    longint held_a;
    held_v = 1'b0;
    held_a = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (held_v) begin
          check(out_valid == 1'b1 && out_addr == ADDR_W'(held_a), "R8 stall hold",
                longint'(out_addr), held_a);
        end
        held_v = 1'b0;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6/R9 unexpected output", longint'(out_addr), 0);
          end else begin
            longint e;
            int     a;
            bit     ns;
            e  = exp_q.pop_front();
            a  = acc_q.pop_front();
            ns = nost_q.pop_front();
            check(out_addr == ADDR_W'(e), "R1/R2/R3/R4/R5/R9 address", longint'(out_addr), e);
            if (ns && !stall_mode)
              check((cyc + 1 - a) == 2, "R7 latency", longint'(cyc + 1 - a), 2);
          end
        end else if (out_valid) begin
          held_v = 1'b1;
          held_a = longint'(out_addr);
        end
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    stall_mode = 1'b0;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_x = '0; in_y = '0; pitch_blocks = '0; blk_h_code = '0; base_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 reset out_valid", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R10 reset in_ready", longint'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed corners, back to back, no stall (R7 timing checked here)
    drive(0, 0, 4, 0, 0);            // R1 origin
    drive(63, 7, 4, 0, 0);           // R1 last byte of a GOB -> 511
    drive(16, 0, 4, 0, 0);           // R1 second sector -> 32
    drive(0, 2, 4, 0, 0);            // R1 sector below -> 64
    drive(5, 1, 4, 0, 0);            // R1 second line of sector -> 21
    drive(64, 0, 4, 0, 0);           // R3 next block column -> 512
    drive(0, 8, 4, 0, 0);            // R4 next block row, single-GOB blocks
    drive(0, 8, 4, 2, 0);            // R2 second GOB inside a 4-GOB block
    drive(0, 32, 3, 2, 0);           // R4 next block row with 4-GOB blocks
    drive(130, 300, 7, 5, 64'h12_3456_7000); // R5 base with 32-GOB blocks
    drive(1, 1, 1, 6, 0);            // R6 illegal code, dropped
    drive(64, 8, 2, 3, 64'h100);     // R2/R3 after a dropped beat
    drive(2, 2, 2, 15, 0);           // R6 illegal code, dropped
    drive(65535, 65535, 4095, 5, 64'hFF_FFFF_FFFF); // R5 wrap at ADDR_W
    drain();
    check(exp_q.size() == 0, "R6/R9 queue empty after directed", exp_q.size(), 0);

    // Random traffic with downstream stalls
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      drive({$urandom} % 65536, {$urandom} % 65536, {$urandom} % 4096,
            {$urandom} % 8, {longint'($urandom), 32'($urandom)} & 64'hFF_FFFF_FFFF);
    end
    drain();
    check(exp_q.size() == 0, "R9 queue empty after random", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule